// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block receives serial words as the clock master of a two-wire synchronous link. A baud tick from outside paces a shift clock that the block drives itself. The far end changes the data line while that clock is high, and the receiver samples the line on each falling edge. Words are 8 bits, or 9 bits when the ninth-bit option is on. The bits arrive least-significant first, and the ninth bit, when present, arrives last.

Software starts reception in one of two ways. A one-word request collects exactly one word and then withdraws itself. A continuous enable keeps collecting words until it is dropped. If both are set, the continuous enable wins. Finished words, each with its ninth bit, go into a two-entry queue. A data-available flag and an optional interrupt tell software when the queue holds a word. The ninth-bit output belongs to the entry at the head of the queue, so software reads it before it pops the data.

If a word completes while the queue is full, that word is thrown away and a sticky overrun flag is raised. While overrun is set, the receiver stops entirely. The only way to clear overrun is to take the continuous enable from high to low. That same falling edge also discards any word that is only partly received.

Top module: `sync_master_rx`

## Requirements
- R1: While rst_n is low and just after it is released, sclk, data_avail, overrun, irq, single_busy, rd_bit9 and rd_data are all 0.
- R2: sclk rests at 0 whenever no reception is active. Reception is inactive when port_en is 0, when neither enable is set, or when overrun is set. While active, sclk toggles only on baud_tick cycles, and its first change is a rise.
- R3: On every falling edge of sclk the receiver samples rx_in. Word bit 0 is sampled first. With word9_en=1 the ninth sampled bit appears on rd_bit9; with word9_en=0 rd_bit9 reads 0 for that entry.
- R4: A pulse on single_start (with port_en=1 and cont_en=0) produces exactly one word: 8 sclk rises, or 9 when word9_en=1. single_busy then returns to 0.
- R5: While cont_en=1, words are received one after another. When cont_en falls, any partly received word is discarded, sclk stays at 0 and no further word enters the queue.
- R6: With single_start and cont_en both set, continuous mode wins, and words keep arriving after the first one completes.
- R7: The queue holds two words and returns them in arrival order. rd_data and rd_bit9 show the oldest entry, and pop moves to the next one. data_avail is 1 while any entry is held and returns to 0 only when pops have emptied the queue.
- R8: A word that completes while the queue holds two entries is discarded and overrun goes to 1. While overrun is 1, no word enters the queue and sclk stays at 0, even after the queue is emptied.
- R9: Once set, overrun stays at 1 through pops and idle time. It clears only on a cycle in which cont_en has gone from 1 to 0.
- R10: A pop while the queue is empty changes nothing: rd_data and rd_bit9 keep the last word popped and data_avail stays 0.
- R11: irq is 1 exactly when data_avail is 1 and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Puts the port in synchronous master receive mode |
| baud_tick | input | 1 | One-cycle pulse; each pulse is one half period of sclk |
| single_start | input | 1 | Pulse that requests a single word |
| cont_en | input | 1 | Continuous receive enable; its falling edge clears overrun |
| word9_en | input | 1 | Selects 9-bit words |
| irq_en | input | 1 | Gates data_avail onto irq |
| pop | input | 1 | Removes the head entry of the queue |
| rx_in | input | 1 | Serial data line |
| sclk | output | 1 | Shift clock driven to the far end |
| rd_data | output | DATA_W | Data of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| data_avail | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky overrun flag |
| single_busy | output | 1 | A single-word request is pending |
| irq | output | 1 | data_avail gated by irq_en |

## Verification
The properties assume that word9_en and port_en do not change in the middle of a word, and that pop is a one-cycle pulse on a clean clock cycle. The bench changes word9_en and port_en only while the receiver is idle, and it raises pop for one cycle at a time. The far end is modelled by a process that puts the next bit on rx_in at each rise of sclk, so every bit is settled well before the falling edge that samples it. The bench keeps baud_tick free-running at one pulse every four cycles, and the clock-pacing properties rely on that fixed spacing of the tick.

// File: rtl/sync_rx_pkg.sv
// Package: shared types for the synchronous master receiver.
// Assumes: nothing; it holds only declarations.
package sync_rx_pkg;

    // Receive mode that the control logic has selected
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_CONT   = 2'd2
    } rx_mode_e;

    // Number of bits in a word for the selected width
    function automatic int unsigned word_bits(input int unsigned data_w, input logic nine);
        return nine ? data_w + 1 : data_w;
    endfunction

endpackage

// File: rtl/sync_rx_ctrl.sv
// Module: sync_rx_ctrl
// Chooses the receive mode from the two enables, with continuous taking
// precedence. Holds the self-clearing single-word request and the sticky
// overrun flag, and decides whether a finished word goes into the queue.
// Assumes: word_done is a one-cycle pulse from the shifter, and fifo_full
// is the queue state in the same cycle.
module sync_rx_ctrl
    import sync_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     port_en,
    input  logic     single_start,
    input  logic     cont_en,
    input  logic     word_done,
    input  logic     fifo_full,
    output logic     active,
    output logic     abort,
    output logic     push,
    output logic     overrun,
    output logic     single_busy,
    output rx_mode_e mode
);

    logic cont_prev_q;
    logic single_q;
    logic ovr_q;
    logic cont_fall;

    assign cont_fall = cont_prev_q & ~cont_en;

    // Pick the mode: continuous wins over single
    always_comb begin
        if (cont_en)       mode = MODE_CONT;
        else if (single_q) mode = MODE_SINGLE;
        else               mode = MODE_IDLE;
    end

    assign active      = port_en && !ovr_q && (mode != MODE_IDLE);
    assign abort       = cont_fall;
    assign push        = word_done && !fifo_full && !ovr_q;
    assign overrun     = ovr_q;
    assign single_busy = single_q;

    // Remember cont_en from the previous cycle to detect its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) cont_prev_q <= 1'b0;
        else        cont_prev_q <= cont_en;
    end

    // Single-word request: set by the start pulse, cleared on completion or abort
    always_ff @(posedge clk) begin
        if (!rst_n)                          single_q <= 1'b0;
        else if (cont_fall || word_done)     single_q <= 1'b0;
        else if (single_start && port_en)    single_q <= 1'b1;
    end

    // Sticky overrun: set by a word that finds the queue full, cleared by cont_en falling
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovr_q <= 1'b0;
        else if (cont_fall)               ovr_q <= 1'b0;
        else if (word_done && fifo_full)  ovr_q <= 1'b1;
    end

endmodule

// File: rtl/sync_rx_shift.sv
// Module: sync_rx_shift
// Drives the shift clock from the baud tick. Samples the data line on each
// falling edge and places the bits least-significant first. Marks the edge
// that completes a word and presents the finished word in that cycle.
// Assumes: nine_bit is stable during a word. A word is DATA_W or DATA_W+1 bits.
module sync_rx_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              abort,
    input  logic              baud_tick,
    input  logic              nine_bit,
    input  logic              rx_in,
    output logic              sclk,
    output logic              word_done,
    output logic [DATA_W:0]   word
);

    localparam int unsigned WORD_W = DATA_W + 1;
    localparam int unsigned CNT_W  = $clog2(WORD_W);

    logic              sclk_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W:0]   shreg_q;
    logic [CNT_W-1:0]  last_idx;
    logic              fall_now;

    assign last_idx  = nine_bit ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    assign fall_now  = active && !abort && baud_tick && sclk_q;
    assign word_done = fall_now && (cnt_q == last_idx);
    assign sclk      = sclk_q;

    // Toggle the shift clock on ticks; sample and count on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (!active || abort) begin
            sclk_q <= 1'b0;
            cnt_q  <= '0;
        end else if (baud_tick) begin
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
                shreg_q[cnt_q] <= rx_in;
                cnt_q          <= (cnt_q == last_idx) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // Finished word: stored bits plus the bit sampled on the final edge
    always_comb begin
        word        = shreg_q;
        word[cnt_q] = rx_in;
        if (!nine_bit) word[DATA_W] = 1'b0;
    end

endmodule

// File: rtl/sync_rx_fifo.sv
// Module: sync_rx_fifo
// A small receive queue. The head entry is visible at all times. When the
// queue is empty the output keeps the last entry popped, and a pop while
// empty does nothing.
// Assumes: the caller does not push while full; such a push is dropped.
module sync_rx_fifo #(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] last_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             push_ok;
    logic             pop_ok;

    assign push_ok = push && (cnt_q != CNT_W'(DEPTH));
    assign pop_ok  = pop && (cnt_q != '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign rdata   = (cnt_q != '0) ? mem[rd_ptr_q] : last_q;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // One storage register per entry
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        logic [WIDTH-1:0] entry_q;

        // Capture the pushed word when this entry is the write target
        always_ff @(posedge clk) begin
            if (!rst_n)                                      entry_q <= '0;
            else if (push_ok && (wr_ptr_q == PTR_W'(gi)))    entry_q <= wdata;
        end

        assign mem[gi] = entry_q;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Keep the most recently popped entry for reads while empty
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= '0;
        else if (pop_ok) last_q <= mem[rd_ptr_q];
    end

endmodule

// File: rtl/sync_master_rx.sv
// Module: sync_master_rx
// Top level of the synchronous master receiver. Connects the mode and
// overrun control, the clock and shift path, and the receive queue, and
// gates the data-available flag onto the interrupt.
// Assumes: baud_tick is a single-cycle pulse. Inputs are synchronous to clk.
module sync_master_rx
    import sync_rx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              baud_tick,
    input  logic              single_start,
    input  logic              cont_en,
    input  logic              word9_en,
    input  logic              irq_en,
    input  logic              pop,
    input  logic              rx_in,
    output logic              sclk,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              data_avail,
    output logic              overrun,
    output logic              single_busy,
    output logic              irq
);

    localparam int unsigned WORD_W = DATA_W + 1;
    localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);

    logic              active;
    logic              abort;
    logic              push;
    logic              word_done;
    logic              fifo_full;
    logic [DATA_W:0]   word;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;
    rx_mode_e          mode;

    sync_rx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_en      (port_en),
        .single_start (single_start),
        .cont_en      (cont_en),
        .word_done    (word_done),
        .fifo_full    (fifo_full),
        .active       (active),
        .abort        (abort),
        .push         (push),
        .overrun      (overrun),
        .single_busy  (single_busy),
        .mode         (mode)
    );

    sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .abort     (abort),
        .baud_tick (baud_tick),
        .nine_bit  (word9_en),
        .rx_in     (rx_in),
        .sclk      (sclk),
        .word_done (word_done),
        .word      (word)
    );

    sync_rx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (word),
        .pop   (pop),
        .rdata (head),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    assign rd_data    = head[DATA_W-1:0];
    assign rd_bit9    = head[DATA_W];
    assign data_avail = (fifo_cnt != '0);
    assign irq        = data_avail & irq_en;

endmodule

// File: rtl/sync_master_rx_chk.sv
// Module: sync_master_rx_chk
// Checker for sync_master_rx, bound into the top module. It watches the
// ports and the queue occupancy.
// Assumes: it is bound with the parameters of the top module.
module sync_master_rx_chk #(
    parameter int unsigned FIFO_DEPTH = 2,
    parameter int unsigned CNT_W      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic             baud_tick,
    input logic             cont_en,
    input logic             irq_en,
    input logic             pop,
    input logic             sclk,
    input logic             data_avail,
    input logic             overrun,
    input logic             irq,
    input logic [CNT_W-1:0] fifo_cnt
);

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !sclk) else $error("AST_IDLE_CLK_LOW");                        // R2

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(baud_tick)) else $error("AST_SCLK_ON_TICK");          // R2

    AST_OVR_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !sclk) else $error("AST_OVR_CLK_HELD");                          // R8

    AST_OVR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> (fifo_cnt <= $past(fifo_cnt))) else $error("AST_OVR_NO_PUSH");   // R8

    AST_OVR_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> !$past(cont_en)) else $error("AST_OVR_CLEAR_SRC");        // R9

    AST_AVAIL_FALL_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> $past(pop)) else $error("AST_AVAIL_FALL_POP");         // R7

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(FIFO_DEPTH)) else $error("AST_FIFO_BOUND");               // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && data_avail)) else $error("AST_IRQ_GATED");                // R11

endmodule

bind sync_master_rx sync_master_rx_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      ($clog2(FIFO_DEPTH + 1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .baud_tick  (baud_tick),
    .cont_en    (cont_en),
    .irq_en     (irq_en),
    .pop        (pop),
    .sclk       (sclk),
    .data_avail (data_avail),
    .overrun    (overrun),
    .irq        (irq),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/sync_master_rx_bench.sv
`timescale 1ns/1ps
module sync_master_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       single_start = 1'b0;
    logic       cont_en = 1'b0;
    logic       word9_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       pop_mon = 1'b0;
    logic       pop_man = 1'b0;
    logic       pop;
    logic       rx_in = 1'b0;
    logic       sclk;
    logic [7:0] rd_data;
    logic       rd_bit9;
    logic       data_avail;
    logic       overrun;
    logic       single_busy;
    logic       irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  rises    = 0;
    int  rx_words = 0;
    int  tick_cnt = 0;
    bit  auto_pop = 1'b0;
    bit  done     = 1'b0;
    logic       sclk_prev = 1'b0;
    bit         bit_stream[$];
    logic [8:0] exp_q[$];

    assign pop = pop_mon | pop_man;

    always #2.5 clk = ~clk;

    sync_master_rx u_sync_master_rx (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .baud_tick(baud_tick),
        .single_start(single_start), .cont_en(cont_en), .word9_en(word9_en),
        .irq_en(irq_en), .pop(pop), .rx_in(rx_in), .sclk(sclk), .rd_data(rd_data),
        .rd_bit9(rd_bit9), .data_avail(data_avail), .overrun(overrun),
        .single_busy(single_busy), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, actual, expected);
        end
    endtask

    // Free-running baud tick, one pulse every four cycles
    always @(negedge clk) begin
        tick_cnt  = (tick_cnt + 1) % 4;
        baud_tick = (tick_cnt == 0);
    end

    // Far-end model: present the next bit at each rise of sclk
    always @(negedge clk) begin
        if (sclk && !sclk_prev) begin
            rises++;
            rx_in = (bit_stream.size() != 0) ? bit_stream.pop_front() : 1'b0;
        end
        sclk_prev = sclk;
    end

    // Scoreboard monitor: pop each delivered word and compare with the queue
    always @(negedge clk) begin
        if (pop_mon) pop_mon = 1'b0;
        else if (auto_pop && data_avail) begin
            if (exp_q.size() == 0)
                check(1'b0, "R5", "unexpected word", {rd_bit9, rd_data}, 0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({rd_bit9, rd_data} == e, "R3", "received word", {rd_bit9, rd_data}, e);
            end
            rx_words++;
            pop_mon = 1'b1;
        end
    end

    // Driver: queue one word on the line and optionally in the scoreboard
    task automatic send_word(input logic [7:0] d, input logic b9, input bit expect_it);
        for (int i = 0; i < 8; i++) bit_stream.push_back(d[i]);
        if (word9_en) bit_stream.push_back(b9);
        if (expect_it) exp_q.push_back({word9_en ? b9 : 1'b0, d});
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_words(input int n, input string req);
        int t = 0;
        while (rx_words < n && t < 5000) begin @(negedge clk); t++; end
        check(rx_words >= n, req, "word count reached", rx_words, n);
    endtask

    task automatic pulse_start();
        @(negedge clk); single_start = 1'b1;
        @(negedge clk); single_start = 1'b0;
    endtask

    task automatic manual_pop();
        @(negedge clk); pop_man = 1'b1;
        @(negedge clk); pop_man = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        cycles(150000);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int r0;
        int w0;
        cycles(5);
        // R1: reset state
        check(sclk == 0, "R1", "sclk in reset", sclk, 0);
        check(data_avail == 0 && overrun == 0 && irq == 0, "R1", "flags in reset",
              {data_avail, overrun, irq}, 0);
        rst_n = 1'b1;
        cycles(1);
        check({single_busy, rd_bit9, rd_data} == 0, "R1", "outputs after reset",
              {single_busy, rd_bit9, rd_data}, 0);

        // R2: start request while port disabled is ignored; idle clock stays low
        pulse_start();
        cycles(40);
        check(rises == 0 && single_busy == 0, "R2", "no clock while port off", rises, 0);
        port_en = 1'b1;
        cycles(40);
        check(rises == 0, "R2", "no clock with no enable", rises, 0);

        // R4: single 8-bit word
        auto_pop = 1'b1;
        send_word(8'hA5, 1'b0, 1'b1);
        r0 = rises;
        pulse_start();
        wait_words(1, "R4");
        cycles(100);
        check(rises - r0 == 8, "R4", "sclk rises for one 8-bit word", rises - r0, 8);
        check(single_busy == 0 && sclk == 0, "R4", "single self-cleared", single_busy, 0);

        // R3: single 9-bit word, ninth bit last
        word9_en = 1'b1;
        send_word(8'h3C, 1'b1, 1'b1);
        r0 = rises;
        pulse_start();
        wait_words(2, "R3");
        cycles(100);
        check(rises - r0 == 9, "R3", "sclk rises for one 9-bit word", rises - r0, 9);
        word9_en = 1'b0;

        // R5: continuous words, then abort a partial one
        send_word(8'h01, 1'b0, 1'b1);
        send_word(8'h80, 1'b0, 1'b1);
        send_word(8'hFF, 1'b0, 1'b1);
        send_word(8'h5A, 1'b0, 1'b1);
        @(negedge clk); cont_en = 1'b1;
        wait_words(6, "R5");
        cycles(12);
        cont_en = 1'b0;
        bit_stream.delete();
        cycles(2);
        r0 = rises; w0 = rx_words;
        cycles(150);
        check(rises == r0 && sclk == 0, "R5", "clock stops after abort", rises - r0, 0);
        check(rx_words == w0 && data_avail == 0, "R5", "partial word dropped", rx_words - w0, 0);

        // R6: both enables set, continuous wins
        send_word(8'h12, 1'b0, 1'b1);
        send_word(8'h34, 1'b0, 1'b1);
        send_word(8'h56, 1'b0, 1'b1);
        @(negedge clk); single_start = 1'b1; cont_en = 1'b1;
        @(negedge clk); single_start = 1'b0;
        wait_words(w0 + 3, "R6");
        check(rx_words - w0 == 3, "R6", "words beyond the first", rx_words - w0, 3);
        cont_en = 1'b0;
        bit_stream.delete();
        cycles(20);
        check(single_busy == 0, "R6", "single request cleared", single_busy, 0);
        check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);

        // R11: interrupt gating
        auto_pop = 1'b0;
        send_word(8'h77, 1'b0, 1'b0);
        pulse_start();
        for (int t = 0; t < 500 && !data_avail; t++) @(negedge clk);
        check(data_avail == 1 && irq == 0, "R11", "irq masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1, "R11", "irq enabled", irq, 1);
        check(rd_data == 8'h77, "R7", "head data", rd_data, 8'h77);
        manual_pop();
        @(negedge clk);
        check(data_avail == 0 && irq == 0, "R11", "irq drops when empty", irq, 0);
        irq_en = 1'b0;

        // R8: fill the queue and overrun with a third word
        word9_en = 1'b1;
        send_word(8'h11, 1'b1, 1'b0);
        send_word(8'h22, 1'b0, 1'b0);
        send_word(8'h33, 1'b1, 1'b0);
        @(negedge clk); cont_en = 1'b1;
        for (int t = 0; t < 2000 && !overrun; t++) @(negedge clk);
        check(overrun == 1, "R8", "overrun set", overrun, 1);
        check({rd_bit9, rd_data} == 9'h111, "R7", "oldest entry first", {rd_bit9, rd_data}, 9'h111);
        r0 = rises;
        cycles(100);
        check(rises == r0, "R8", "clock frozen in overrun", rises - r0, 0);
        manual_pop();
        @(negedge clk);
        check({rd_bit9, rd_data} == 9'h022, "R7", "second entry and its ninth bit",
              {rd_bit9, rd_data}, 9'h022);
        check(data_avail == 1, "R7", "flag held with one entry", data_avail, 1);
        manual_pop();
        @(negedge clk);
        check(data_avail == 0, "R7", "flag clears when empty", data_avail, 0);
        check({rd_bit9, rd_data} == 9'h022, "R10", "last value kept", {rd_bit9, rd_data}, 9'h022);
        manual_pop();
        @(negedge clk);
        check({data_avail, rd_bit9, rd_data} == 10'h022, "R10", "empty pop no effect",
              {data_avail, rd_bit9, rd_data}, 10'h022);
        r0 = rises;
        cycles(100);
        check(rises == r0 && data_avail == 0, "R8", "no transfer while overrun", rises - r0, 0);
        check(overrun == 1, "R9", "overrun sticky", overrun, 1);
        cont_en = 1'b0;
        cycles(2);
        check(overrun == 0, "R9", "overrun cleared by cont_en fall", overrun, 0);
        word9_en = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule